// File: doc/BRIEF.md
# Wave-Pipelined Four-Input Decision-Tree Lookup Slice

This block is a four-input, one-output lookup slice built as a binary tree of 2:1 selectors. Sixteen configuration bits sit at the leaves. Each tree level is steered by one bit of the input vector, and evaluation climbs from the leaves toward the root. The root gives the function value, so any Boolean function of up to four variables can be loaded.

The tree is cut into two stages. The lower stage holds the two leaf-side levels and is steered by input bits 0 and 1. The upper stage holds the two root-side levels and is steered by bits 2 and 3. The two halves of a two-phase clock are modelled as alternating cycles of one clock, tracked by a phase bit that toggles every cycle. The lower stage captures its wave at the end of a phase-0 cycle, and the upper stage captures at the end of the following phase-1 cycle. A feeder register holds the upper select bits for that extra phase, so each vector meets its own wave. While the wave advances, the input drivers block new select values, and this keeps successive waves apart. A new vector can enter in every phase-0 cycle.

The configuration is written through a simple load strobe. A write is only supported while no vector is in flight.

Top module: `wslut_slice`

## Requirements
- R1: During reset and in the first cycle after it, `phase`, `out_valid` and `out_bit` are all 0.
- R2: `phase` is 0 in the first cycle after reset and inverts in every cycle after that.
- R3: A vector is accepted when `in_valid` is 1 in a cycle with `phase` at 0. `out_valid` is then 1 in exactly the cycle two cycles later, for that one cycle only, and that cycle always has `phase` at 0.
- R4: For an accepted vector v, `out_bit` in its result cycle equals configuration bit number v. Here v is `in_vec` read as an unsigned number with bit 0 as the least significant bit, and configuration bit i is `cfg_data[i]`.
- R5: `in_valid` in a cycle with `phase` at 1 has no effect. It produces no result, and `out_bit` keeps its value.
- R6: Vectors offered in every phase-0 cycle back to back each give their own correct result, with one result every two cycles.
- R7: Once a vector has been accepted, changes on `in_vec` in the next cycle, including changes on bits 2 and 3, do not change that vector's result.
- R8: `cfg_we` at 1 loads `cfg_data` at the clock edge. Vectors accepted after the load use the new bits, and the load itself leaves `out_bit` unchanged.
- R9: While `out_valid` is 0, `out_bit` holds the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each cycle is one phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the leaf bits |
| cfg_data | input | 16 | Leaf bits; bit i is the function value for input vector i |
| in_valid | input | 1 | Input vector offered this cycle |
| in_vec | input | 4 | Input variables; bit 0 steers the leaf level |
| phase | output | 1 | Current phase; vectors are taken only when 0 |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_bit | output | 1 | Function value; holds between results |

## Verification
The sweep covers every input vector under each of the sixteen one-hot leaf patterns and under several dense patterns. Together these catch a design that swaps select bits or misorders the levels, because such a design returns a neighbouring leaf. In each phase-1 cycle the bench offers the inverted vector with `in_valid` high. A feeder that does not hold the upper select bits would then take its upper path from the wrong vector. A design that samples in the wrong phase would emit extra or misplaced results. The bench also checks that `out_bit` holds between pulses and across configuration loads, which exposes an output register that updates without a valid result.

// File: rtl/wslut_slice.sv
module wslut_slice #(
  parameter int NV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [(1<<NV)-1:0] cfg_data,
  input  logic              in_valid,
  input  logic [NV-1:0]     in_vec,
  output logic              phase,
  output logic              out_valid,
  output logic              out_bit
);
  localparam int NL = 1 << NV;
  localparam int LO = NV / 2;
  localparam int HI = NV - LO;
  localparam int LW = 1 << LO;
  localparam int NP = 1 << HI;

  logic [NL-1:0] cfg_q;
  logic [NP-1:0] part_d, part_q;
  logic [HI-1:0] hi_q;
  logic [LO-1:0] lo_sel;
  logic          a_valid;

  assign lo_sel = in_vec[LO-1:0];

  for (genvar j = 0; j < NP; j++) begin : g_lower
    logic [LW-1:0] grp;
    assign grp       = cfg_q[j*LW +: LW];
    assign part_d[j] = grp[lo_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      cfg_q     <= '0;
      part_q    <= '0;
      hi_q      <= '0;
      a_valid   <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      phase <= ~phase;
      if (cfg_we) cfg_q <= cfg_data;
      if (!phase) begin
        a_valid   <= in_valid;
        out_valid <= 1'b0;
        if (in_valid) begin
          part_q <= part_d;
          hi_q   <= in_vec[NV-1:LO];
        end
      end else begin
        out_valid <= a_valid;
        if (a_valid) out_bit <= part_q[hi_q];
      end
    end
  end

  assert_valid_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !phase);
  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !phase) |-> ##2 out_valid);
  assert_no_phantom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid, 2) && !$past(phase, 2)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_bit));
  assert_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bit == cfg_q[$past(in_vec, 2)]));
endmodule

// File: tb/wslut_slice_tb.sv
module wslut_slice_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic [3:0] in_vec = '0;
  logic phase, out_valid, out_bit;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic exp_ph;
  logic [15:0] cfg_m;
  bit pend;
  logic pend_val;
  logic hold_val;

  always #10 clk = ~clk;

  wslut_slice u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_vec(in_vec), .phase(phase),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic chk(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic next();
    @(negedge clk);
    exp_ph = ~exp_ph;
    chk("R2 phase", phase, exp_ph);
  endtask

  // in a phase-0 cycle: check pending result, offer v, then in phase 1 offer junk
  task automatic do_vec(input logic [3:0] v);
    chk("R3 valid pulse", out_valid, pend);
    if (pend) begin
      chk("R4 R6 result", out_bit, pend_val);
      hold_val = pend_val;
    end
    in_valid = 1'b1;
    in_vec = v;
    pend = 1'b1;
    pend_val = cfg_m[v];
    next();
    chk("R5 no valid in phase 1", out_valid, 1'b0);
    chk("R9 hold", out_bit, hold_val);
    in_valid = 1'b1;
    in_vec = ~v; // R7: upper bits change after acceptance
    next();
  endtask

  task automatic flush();
    chk("R3 valid pulse", out_valid, pend);
    if (pend) begin
      chk("R4 R7 result", out_bit, pend_val);
      hold_val = pend_val;
    end
    pend = 1'b0;
    in_valid = 1'b0;
    next();
    chk("R9 hold idle", out_valid, 1'b0);
    chk("R9 hold idle bit", out_bit, hold_val);
    next();
  endtask

  task automatic load(input logic [15:0] c);
    cfg_we = 1'b1;
    cfg_data = c;
    cfg_m = c;
    next();
    cfg_we = 1'b0;
    chk("R8 load keeps out_bit", out_bit, hold_val);
    chk("R8 load no valid", out_valid, 1'b0);
    next();
    chk("R8 load keeps out_bit", out_bit, hold_val);
  endtask

  task automatic sweep(input logic [15:0] c);
    load(c);
    for (int v = 0; v < 16; v++) do_vec(v[3:0]);
    flush();
  endtask

  initial begin
    exp_ph = 1'b0;
    cfg_m = '0;
    pend = 1'b0;
    pend_val = 1'b0;
    hold_val = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset phase", phase, 1'b0);
    chk("R1 reset valid", out_valid, 1'b0);
    chk("R1 reset bit", out_bit, 1'b0);
    rst_n = 1'b1;
    chk("R1 post-reset phase", phase, 1'b0);
    chk("R1 post-reset valid", out_valid, 1'b0);
    for (int k = 0; k < 16; k++) sweep(16'h1 << k);
    sweep(16'h0000);
    sweep(16'hFFFF);
    sweep(16'h6996);
    sweep(16'hA5C3);
    sweep(16'h1234);
    sweep(16'hF00F);
    for (int s = 1; s < 6; s++) sweep(16'((s * 40503 + 12345) & 16'hFFFF));
    // R8: reload with complement and reuse vectors
    sweep(16'h5A3C);
    sweep(~16'h5A3C);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule